// File: doc/BRIEF.md
# Single-Register MDIO Management Master

This block gives software a clause-22 MDIO master behind one 32-bit command word. One write carries the whole transaction: the target PHY, the register inside it, the direction, the data to send and a start flag. When the start flag is set, the block runs a full management frame on MDC and MDIO. The start flag then stays set until the frame ends, so software polls that one bit to wait for completion.

A read frame returns its 16 received bits in the low half of the same word, and they are in place by the time the start flag clears. MDC is derived from the system clock by an even divisor. The master drives MDIO while MDC is low and samples it on the MDC rising edge. During the turnaround and data phases of a read it releases the line. A command that names a PHY outside the supported range, or that has the master enable bit clear, stores its fields but never starts a frame.

Top module: `mdio_ctl_master`

## Requirements
- R1: After reset the command word reads 0, MDC is low and the MDIO output enable is low.
- R2: The command word packs write/read data in [15:0], the PHY register number in [20:16], the PHY address in [25:21], the direction flag in [27] (1 = read, 0 = write), the master enable in [30] and the busy flag in [31]. Bits 26, 28 and 29 always read 0. A write with bit 31 clear stores the fields and reads back in this layout on the next cycle.
- R3: A write with bit 31 set, bit 30 set and a PHY address below NUM_PHYS (5) starts a frame, and bit 31 reads 1 from the next cycle.
- R4: A start request with a PHY address of NUM_PHYS or more runs no frame. Bit 31 reads 0 and MDIO stays undriven.
- R5: A start request with bit 30 clear runs no frame and leaves bit 31 at 0.
- R6: A write frame sends 64 bits MSB first: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the 16 data bits, with the output enable high for every bit.
- R7: A read frame sends opcode 10. The output enable is high for the first 46 bits and low for the two turnaround bits and the 16 data bits. The data bits are sampled on MDC rising edges, MSB first.
- R8: Each bit lasts DIV system clocks. MDC is low for the first DIV/2 clocks of a bit and high for the rest, and MDIO changes only while MDC is low.
- R9: A write to the command word while bit 31 is set has no effect on the stored fields or on the running frame.
- R10: Bit 31 clears exactly 64*DIV+1 clocks after the accepting edge. After a read, the received data is in [15:0] from that same cycle.
- R11: While no frame is running, MDC stays low and the MDIO output enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Value written to the command word |
| cmd_rdata | output | 32 | Current command word, including busy and read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
A write frame is checked bit by bit, which shows that the opcode, both address fields and the data land in the right slots and that the line is driven for all 64 bits. A read frame, sent to the highest valid PHY, returns a non-symmetric pattern. This separates a correct MSB-first capture from a reversed or shifted one, and it shows exactly where the line is released. A stray write made during a frame, and start requests with address 5 or with the enable bit clear, show whether the guards keep both the stored word and the pins unchanged. Counting the clocks to the busy clear and the clocks MDC spends high pins down the frame length and the MDC duty cycle.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;

    typedef enum logic { SEQ_IDLE, SEQ_RUN } seq_state_e;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdm_cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdm_cmd_t c);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] pay;
        op  = c.rd ? 2'b10 : 2'b01;
        ta  = c.rd ? 2'b00 : 2'b10;
        pay = c.rd ? 16'h0000 : c.data;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta, pay};
    endfunction

endpackage

// File: rtl/mdm_clkgen.sv
module mdm_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mdc_o,
    output logic bit_end_o,
    output logic smp_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } clk_st_t;

    clk_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else begin
            if (st_q.cnt == CW'(DIV - 1)) st_d.cnt = '0;
            else                          st_d.cnt = st_q.cnt + 1'b1;
            st_d.mdc = (st_d.cnt >= CW'(HALF));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o     = st_q.mdc;
    assign bit_end_o = run_i && (st_q.cnt == CW'(DIV - 1));
    assign smp_o     = run_i && (st_q.cnt == CW'(HALF - 1));

    AST_MDC_RISE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mdc) |-> (st_q.cnt == CW'(HALF))) else $error("mdc rise off-centre"); // R8

    AST_MDC_FALL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.mdc) |-> (st_q.cnt == '0)) else $error("mdc fell mid-bit"); // R8

endmodule

// File: rtl/mdm_seq.sv
module mdm_seq
    import mdm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  mdm_cmd_t    cmd_i,
    input  logic        bit_end_i,
    input  logic        smp_i,
    input  logic        mdio_i,
    output logic        run_o,
    output logic        mdo_o,
    output logic        oe_o,
    output logic        done_o,
    output logic [15:0] rx_o
);
    localparam int BW = $clog2(FRAME_BITS);

    typedef struct packed {
        seq_state_e            state;
        logic [BW-1:0]         bitn;
        logic [FRAME_BITS-1:0] sh;
        logic                  rd;
        logic                  mdo;
        logic                  oe;
        logic                  done;
        logic [15:0]           rx;
    } seq_st_t;

    seq_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    st_d.state = SEQ_RUN;
                    st_d.bitn  = '0;
                    st_d.sh    = build_frame(cmd_i);
                    st_d.rd    = cmd_i.rd;
                    st_d.mdo   = st_d.sh[FRAME_BITS-1];
                    st_d.oe    = 1'b1;
                    st_d.rx    = '0;
                end
            end
            SEQ_RUN: begin
                if (smp_i && st_q.rd && (st_q.bitn >= BW'(DATA_FIRST)))
                    st_d.rx = {st_q.rx[14:0], mdio_i};
                if (bit_end_i) begin
                    if (st_q.bitn == BW'(FRAME_BITS - 1)) begin
                        st_d.state = SEQ_IDLE;
                        st_d.oe    = 1'b0;
                        st_d.mdo   = 1'b0;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.bitn = st_q.bitn + 1'b1;
                        st_d.sh   = {st_q.sh[FRAME_BITS-2:0], 1'b0};
                        st_d.mdo  = st_d.sh[FRAME_BITS-1];
                        st_d.oe   = !(st_q.rd && (st_d.bitn >= BW'(TA_FIRST)));
                    end
                end
            end
            default: st_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o  = (st_q.state == SEQ_RUN);
    assign mdo_o  = st_q.mdo;
    assign oe_o   = st_q.oe;
    assign done_o = st_q.done;
    assign rx_o   = st_q.rx;

    AST_TA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SEQ_RUN && st_q.rd && st_q.bitn >= BW'(TA_FIRST)) |-> !st_q.oe)
        else $error("line driven during read turnaround/data"); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done) else $error("done longer than one cycle"); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.state == SEQ_IDLE && !st_q.oe)) else $error("done while running"); // R11

endmodule

// File: rtl/mdm_regif.sv
module mdm_regif
    import mdm_pkg::*;
#(
    parameter int NUM_PHYS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [31:0] wdata_i,
    input  logic        done_i,
    input  logic [15:0] rx_i,
    output logic        start_o,
    output mdm_cmd_t    cmd_o,
    output logic        busy_o,
    output logic [31:0] rword_o
);
    typedef struct packed {
        logic     busy;
        logic     en;
        mdm_cmd_t cmd;
    } reg_st_t;

    reg_st_t  st_q, st_d;
    logic     start;
    mdm_cmd_t wcmd;
    logic     phy_ok;

    always_comb begin
        wcmd.data  = wdata_i[15:0];
        wcmd.regad = wdata_i[20:16];
        wcmd.phy   = wdata_i[25:21];
        wcmd.rd    = wdata_i[27];
        phy_ok     = (32'(wcmd.phy) < NUM_PHYS);
        st_d       = st_q;
        start      = 1'b0;
        if (done_i) begin
            st_d.busy = 1'b0;
            if (st_q.cmd.rd) st_d.cmd.data = rx_i;
        end else if (wr_i && !st_q.busy) begin
            st_d.en   = wdata_i[30];
            st_d.cmd  = wcmd;
            start     = wdata_i[31] && wdata_i[30] && phy_ok;
            st_d.busy = start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o = start;
    assign cmd_o   = wcmd;
    assign busy_o  = st_q.busy;
    assign rword_o = {st_q.busy, st_q.en, 2'b00, st_q.cmd.rd, 1'b0,
                      st_q.cmd.phy, st_q.cmd.regad, st_q.cmd.data};

    AST_BUSY_LOCKS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done_i && wr_i) |=> ($stable(st_q.cmd) && $stable(st_q.en) && st_q.busy))
        else $error("command word changed while busy"); // R9

    AST_BAD_PHY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !st_q.busy && !done_i && (32'(wdata_i[25:21]) >= NUM_PHYS)) |=> !st_q.busy)
        else $error("busy set for out-of-range PHY"); // R4

    AST_NO_EN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !st_q.busy && !done_i && !wdata_i[30]) |=> !st_q.busy)
        else $error("busy set with master disabled"); // R5

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !st_q.busy) else $error("busy not cleared at frame end"); // R10

endmodule

// File: rtl/mdio_ctl_master.sv
module mdio_ctl_master
    import mdm_pkg::*;
#(
    parameter int DIV      = 4,
    parameter int NUM_PHYS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        start, busy, run, bit_end, smp, done;
    logic [15:0] rx;
    mdm_cmd_t    cmd;

    mdm_regif #(.NUM_PHYS(NUM_PHYS)) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cmd_wr),
        .wdata_i (cmd_wdata),
        .done_i  (done),
        .rx_i    (rx),
        .start_o (start),
        .cmd_o   (cmd),
        .busy_o  (busy),
        .rword_o (cmd_rdata)
    );

    mdm_clkgen #(.DIV(DIV)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .mdc_o     (mdc),
        .bit_end_o (bit_end),
        .smp_o     (smp)
    );

    mdm_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .cmd_i     (cmd),
        .bit_end_i (bit_end),
        .smp_i     (smp),
        .mdio_i    (mdio_i),
        .run_o     (run),
        .mdo_o     (mdio_o),
        .oe_o      (mdio_oe),
        .done_o    (done),
        .rx_o      (rx)
    );

    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy) else $error("MDIO driven without a command"); // R11

    AST_MDC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> busy) else $error("MDC toggling while idle"); // R11

    AST_MDIO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o)) else $error("MDIO moved while MDC high"); // R8

endmodule

// File: tb/sim_mdio_ctl_master.sv
`timescale 1ns/1ps
module sim_mdio_ctl_master;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mdio_ctl_master #(.DIV(DIV), .NUM_PHYS(5)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    function automatic logic [31:0] mk(input logic busy, input logic en, input logic rd,
                                       input logic [4:0] phy, input logic [4:0] rg,
                                       input logic [15:0] d);
        return {busy, en, 2'b00, rd, 1'b0, phy, rg, d};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        cmd_wr    = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr    = 1'b0;
    endtask

    // runs one frame, capturing MDIO on each MDC rise and acting as the PHY
    task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] d, input logic [15:0] resp,
                             input logic poke, output logic [63:0] cap,
                             output logic [63:0] cap_oe, output int rises,
                             output int hi, output int glitch);
        logic pm, po;
        write_word(mk(1'b1, 1'b1, rd, phy, rg, d));
        chk(cmd_rdata[31] == 1'b1, "R3 busy after start", 64'(cmd_rdata[31]), 64'd1);
        cap = '0; cap_oe = '0; rises = 0; hi = 0; glitch = 0;
        pm = mdc; po = mdio_o; mdio_i = 1'b1;
        for (int c = 1; c <= 64*DIV; c++) begin
            if (poke && c == 40) begin
                cmd_wr = 1'b1; cmd_wdata = mk(1'b1, 1'b1, ~rd, 5'd1, 5'd9, 16'hDEAD);
            end else begin
                cmd_wr = 1'b0;
            end
            @(negedge clk);
            if (mdc && !pm) begin
                if (rises < 64) begin
                    cap[63-rises]    = mdio_o;
                    cap_oe[63-rises] = mdio_oe;
                end
                rises++;
            end
            if (!mdc && pm)
                mdio_i = (rises >= 48 && rises < 64) ? resp[63-rises] : 1'b1;
            if (mdc && pm && mdio_o != po) glitch++;
            if (mdc) hi++;
            pm = mdc; po = mdio_o;
        end
        cmd_wr = 1'b0;
        chk(cmd_rdata[31] == 1'b1, "R10 busy held through last bit", 64'(cmd_rdata[31]), 64'd1);
        @(negedge clk);
        chk(cmd_rdata[31] == 1'b0, "R10 busy clears one clock after frame", 64'(cmd_rdata[31]), 64'd0);
    endtask

    task automatic t_reset;
        chk(cmd_rdata == 32'h0, "R1 word after reset", 64'(cmd_rdata), 64'd0);
        chk(mdc == 1'b0, "R1 mdc after reset", 64'(mdc), 64'd0);
        chk(mdio_oe == 1'b0, "R1 oe after reset", 64'(mdio_oe), 64'd0);
    endtask

    task automatic t_layout;
        logic [31:0] w;
        w = mk(1'b0, 1'b1, 1'b1, 5'd19, 5'd6, 16'h8C21);
        write_word(w | 32'h3400_0000);   // junk in bits 29,28,26
        chk(cmd_rdata == w, "R2 field readback", 64'(cmd_rdata), 64'(w));
        chk(mdio_oe == 1'b0 && mdc == 1'b0, "R11 idle after plain store",
            64'({mdc, mdio_oe}), 64'd0);
    endtask

    task automatic t_rejects;
        logic seen;
        write_word(mk(1'b1, 1'b1, 1'b0, 5'd5, 5'd3, 16'h1111));
        chk(cmd_rdata[31] == 1'b0, "R4 busy for PHY 5", 64'(cmd_rdata[31]), 64'd0);
        chk(cmd_rdata[25:21] == 5'd5, "R4 fields stored for PHY 5", 64'(cmd_rdata[25:21]), 64'd5);
        seen = 1'b0;
        for (int i = 0; i < 2*DIV; i++) begin
            @(negedge clk);
            if (mdio_oe || mdc) seen = 1'b1;
        end
        chk(!seen, "R4 no line activity for PHY 5", 64'(seen), 64'd0);
        write_word(mk(1'b1, 1'b0, 1'b0, 5'd2, 5'd3, 16'h2222));
        chk(cmd_rdata[31] == 1'b0, "R5 busy with enable clear", 64'(cmd_rdata[31]), 64'd0);
        seen = 1'b0;
        for (int i = 0; i < 2*DIV; i++) begin
            @(negedge clk);
            if (mdio_oe || mdc) seen = 1'b1;
        end
        chk(!seen, "R5 no line activity with enable clear", 64'(seen), 64'd0);
    endtask

    task automatic t_write_frame;
        logic [63:0] cap, cap_oe, exp;
        int rises, hi, glitch;
        run_frame(1'b0, 5'd3, 5'd17, 16'hB4E1, 16'h0, 1'b1, cap, cap_oe, rises, hi, glitch);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd17, 2'b10, 16'hB4E1};
        chk(cap == exp, "R6 write frame bits", cap, exp);
        chk(cap_oe == '1, "R6 oe over write frame", cap_oe, '1);
        chk(rises == 64, "R8 mdc rise count", 64'(rises), 64'd64);
        chk(hi == 64*HALF, "R8 mdc high clocks", 64'(hi), 64'(64*HALF));
        chk(glitch == 0, "R8 mdio steady while mdc high", 64'(glitch), 64'd0);
        chk(cmd_rdata == mk(1'b0, 1'b1, 1'b0, 5'd3, 5'd17, 16'hB4E1),
            "R9 word unchanged by write during busy", 64'(cmd_rdata),
            64'(mk(1'b0, 1'b1, 1'b0, 5'd3, 5'd17, 16'hB4E1)));
        chk(mdio_oe == 1'b0 && mdc == 1'b0, "R11 idle after frame", 64'({mdc, mdio_oe}), 64'd0);
    endtask

    task automatic t_read_frame;
        logic [63:0] cap, cap_oe, exp_oe;
        logic [45:0] exp_hd;
        int rises, hi, glitch;
        run_frame(1'b1, 5'd4, 5'd2, 16'h0000, 16'hA5C3, 1'b0, cap, cap_oe, rises, hi, glitch);
        exp_hd = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd4, 5'd2};
        exp_oe = {{46{1'b1}}, {18{1'b0}}};
        chk(cap[63:18] == exp_hd, "R7 read header bits", 64'(cap[63:18]), 64'(exp_hd));
        chk(cap_oe == exp_oe, "R7 oe released for turnaround and data", cap_oe, exp_oe);
        chk(cmd_rdata[15:0] == 16'hA5C3, "R10 read data at busy clear",
            64'(cmd_rdata[15:0]), 64'h A5C3);
        chk(glitch == 0, "R8 mdio steady during read", 64'(glitch), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_rejects();
        t_write_frame();
        t_read_frame();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule